// File: doc/BRIEF.md
# Frame-Free Oversampled Bit Slicer

The slicer recovers a run of data bits from a serial line that is sampled several times per bit. A strobe, supplied by the surrounding logic, marks the instant at which the first bit begins. From that point the block counts sample ticks within each bit period. It takes three samples around the centre of the period and decides each bit by a two-out-of-three vote. Framing is not enforced: the block does not wait for a falling edge and does not check a closing level. The length of the run is set only by a programmed bit count.

Decided bits are placed into an output word with the first bit at the least significant position. When the programmed number of bits has been decided, a one-cycle completion pulse is raised. The block then goes idle and keeps the word until the next accepted strobe. The oversampling ratio and the widest word are parameters. Clock recovery and drift tracking are left to the surrounding logic.

Top module: `midvote_slicer`

## Requirements
- R1: After reset, `word` is all zeros and `done` is low.
- R2: A `start` pulse seen while idle with a nonzero `nbits` begins a frame. The first `tick` in a later cycle is tick 0 of bit 0. A `tick` in the same cycle as the accepted `start` is not counted.
- R3: Each bit period lasts exactly OSR ticks (default 16), counted 0 to OSR-1. Cycles without `tick` do not advance the count. Bit k+1 begins on the tick that follows tick OSR-1 of bit k.
- R4: Each bit is the majority of `din` sampled on ticks C-1, C and C+1, where C = OSR/2 (ticks 7, 8 and 9 by default). `din` on every other tick has no effect on the result.
- R5: The bit decided k-th in a frame (k from 0) is stored at `word[k]`. `word` is cleared when a frame is accepted, so bits at and above the frame length read 0.
- R6: `done` is high for exactly one cycle per frame. It is visible in the cycle after the clock edge that samples tick C+1 of the last bit. The block is then idle.
- R7: A `start` that arrives while a frame is in progress has no effect. The frame runs on and yields the same word.
- R8: A `start` with `nbits` = 0 is ignored: no frame begins and `word` is unchanged. An `nbits` above MAXBITS is treated as MAXBITS.
- R9: While idle, `word` keeps its last value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample enable, one oversample tick per asserted cycle |
| din | input | 1 | Serial data line |
| start | input | 1 | Strobe that marks the start of the first bit |
| nbits | input | $clog2(MAXBITS+1) | Number of bits in the frame |
| word | output | MAXBITS | Assembled data, first bit at bit 0 |
| done | output | 1 | One-cycle pulse when the last bit is decided |

## Verification
If the tick counter held a wrong phase, the vote would sample the wrong ticks. Noise placed on the ticks away from centre then appears in `word` at the end of the frame. A miscounted bit index or length moves `done` off the exact cycle after the last centre-plus-one tick. It can also put a bit at the wrong position, and the stimulus exposes both as soon as the frame finishes. A frame that lost its busy state would restart on a stray strobe and corrupt the word. A second `done` within one frame would show in the per-frame pulse count.

// File: rtl/midvote_pkg.sv
package midvote_pkg;

    typedef enum logic {
        SL_IDLE = 1'b0,
        SL_RUN  = 1'b1
    } sl_state_e;

    // two-out-of-three decision
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // centre tick of a bit period for a given ratio
    function automatic int unsigned centre_of(input int unsigned osr);
        return osr / 2;
    endfunction

endpackage

// File: rtl/slicer_phase.sv
module slicer_phase #(
    parameter int unsigned OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic tap_lo,
    output logic tap_mid,
    output logic tap_hi
);
    import midvote_pkg::*;

    localparam int unsigned PH_W = $clog2(OSR);
    localparam logic [PH_W-1:0] LAST    = PH_W'(OSR - 1);
    localparam logic [PH_W-1:0] TAP_MID = PH_W'(centre_of(OSR));
    localparam logic [PH_W-1:0] TAP_LO  = PH_W'(centre_of(OSR) - 1);
    localparam logic [PH_W-1:0] TAP_HI  = PH_W'(centre_of(OSR) + 1);

    logic [PH_W-1:0] phase;
    logic            adv;

    assign adv = run & tick & ~clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= '0;
        end else if (adv) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    assign tap_lo  = adv & (phase == TAP_LO);
    assign tap_mid = adv & (phase == TAP_MID);
    assign tap_hi  = adv & (phase == TAP_HI);

    // R3: the phase never leaves the bit period
    assert_phase_range_R3: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);

    // R3: an advancing tick moves the phase by exactly one, wrapping at the end
    assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
        adv |=> phase == (($past(phase) == LAST) ? '0 : $past(phase) + 1'b1));

    // R3: without a tick the phase holds
    assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(phase));

endmodule

// File: rtl/slicer_vote.sv
module slicer_vote (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic tap_lo,
    input  logic tap_mid,
    input  logic tap_hi,
    output logic vote,
    output logic vote_ok
);
    import midvote_pkg::*;

    logic s_lo, s_mid;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_lo  <= 1'b0;
            s_mid <= 1'b0;
        end else begin
            if (tap_lo)  s_lo  <= din;
            if (tap_mid) s_mid <= din;
        end
    end

    assign vote    = maj3(s_lo, s_mid, din);
    assign vote_ok = tap_hi;

    // R4: at most one voting tap is active in any cycle
    assert_taps_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tap_lo, tap_mid, tap_hi}));

    // R4: a tap that is not the middle one leaves the middle sample alone
    assert_mid_sample_kept_R4: assert property (@(posedge clk) disable iff (rst)
        !tap_mid |=> $stable(s_mid));

endmodule

// File: rtl/midvote_slicer.sv
module midvote_slicer #(
    parameter int unsigned OSR     = 16,
    parameter int unsigned MAXBITS = 32,
    localparam int unsigned CNT_W  = $clog2(MAXBITS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               din,
    input  logic               start,
    input  logic [CNT_W-1:0]   nbits,
    output logic [MAXBITS-1:0] word,
    output logic               done
);
    import midvote_pkg::*;

    localparam int unsigned IDX_W = (MAXBITS > 1) ? $clog2(MAXBITS) : 1;
    localparam logic [CNT_W-1:0] MAX_N = CNT_W'(MAXBITS);

    typedef struct packed {
        sl_state_e        st;
        logic [CNT_W-1:0] target;
        logic [CNT_W-1:0] count;
    } frame_t;

    frame_t             fr;
    logic [MAXBITS-1:0] word_q;
    logic               done_q;
    logic               accept;
    logic [CNT_W-1:0]   eff_n;
    logic [CNT_W-1:0]   nxt_cnt;
    logic               tap_lo, tap_mid, tap_hi;
    logic               vote, vote_ok;

    assign eff_n   = (nbits > MAX_N) ? MAX_N : nbits;
    assign accept  = (fr.st == SL_IDLE) & start & (nbits != '0);
    assign nxt_cnt = fr.count + 1'b1;

    slicer_phase #(.OSR(OSR)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .run     (fr.st == SL_RUN),
        .tick    (tick),
        .tap_lo  (tap_lo),
        .tap_mid (tap_mid),
        .tap_hi  (tap_hi)
    );

    slicer_vote u_vote (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .tap_lo  (tap_lo),
        .tap_mid (tap_mid),
        .tap_hi  (tap_hi),
        .vote    (vote),
        .vote_ok (vote_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fr     <= '{st: SL_IDLE, target: '0, count: '0};
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                fr     <= '{st: SL_RUN, target: eff_n, count: '0};
                word_q <= '0;
            end else if (fr.st == SL_RUN && vote_ok) begin
                word_q[fr.count[IDX_W-1:0]] <= vote;
                fr.count <= nxt_cnt;
                if (nxt_cnt == fr.target) begin
                    fr.st  <= SL_IDLE;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign word = word_q;
    assign done = done_q;

    // R6: completion is a single-cycle pulse
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: completion follows a running frame and leaves the block idle
    assert_done_to_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (fr.st == SL_IDLE && $past(fr.st == SL_RUN)));

    // R7: a strobe during a frame changes neither the length nor the position
    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (fr.st == SL_RUN && start && !vote_ok) |=> ($stable(fr.target) && $stable(fr.count)));

    // R9: while idle and not restarted the word holds
    assert_word_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (fr.st == SL_IDLE && !accept) |=> $stable(word));

    // R8: the programmed length never exceeds the word
    assert_target_bound_R8: assert property (@(posedge clk) disable iff (rst)
        fr.target <= MAX_N);

endmodule

// File: tb/sim_midvote_slicer.sv
module sim_midvote_slicer;

    localparam int unsigned OSR     = 16;
    localparam int unsigned MAXBITS = 32;
    localparam int unsigned CNT_W   = $clog2(MAXBITS + 1);
    localparam int unsigned C       = OSR / 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               tick = 1'b0;
    logic               din = 1'b0;
    logic               start = 1'b0;
    logic [CNT_W-1:0]   nbits = '0;
    logic [MAXBITS-1:0] word;
    logic               done;

    int checks = 0;
    int errors = 0;
    int done_seen = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    midvote_slicer #(.OSR(OSR), .MAXBITS(MAXBITS)) u0 (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .din   (din),
        .start (start),
        .nbits (nbits),
        .word  (word),
        .done  (done)
    );

    always @(posedge clk) begin
        if (done) done_seen <= done_seen + 1;
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int unsigned eff_len(input int unsigned n);
        return (n > MAXBITS) ? MAXBITS : n;
    endfunction

    function automatic logic [MAXBITS-1:0] expect_word(input logic [MAXBITS-1:0] data, input int unsigned n);
        logic [MAXBITS-1:0] m;
        m = '0;
        for (int i = 0; i < int'(n); i++) m[i] = 1'b1;
        return data & m;
    endfunction

    // Send one frame. noisy: corrupt off-centre ticks and one of the three taps.
    // busy_kick: raise start again inside the frame.
    task automatic frame(input int unsigned nprog, input logic [MAXBITS-1:0] data,
                         input bit noisy, input bit busy_kick, input string req);
        int unsigned n;
        int unsigned bad_tap;
        logic v;
        n = eff_len(nprog);
        done_seen = 0;
        @(negedge clk);
        nbits = CNT_W'(nprog);
        start = 1'b1;
        tick  = 1'b1;      // tick on the accepting cycle: must not count (R2)
        din   = ~data[0];
        @(negedge clk);
        start = 1'b0;
        tick  = 1'b0;
        for (int b = 0; b < int'(n); b++) begin
            bad_tap = noisy ? ($urandom % 4) : 3;
            for (int t = 0; t < int'(OSR); t++) begin
                v = data[b];
                if (t == int'(C) - 1 || t == int'(C) || t == int'(C) + 1) begin
                    if (int'(bad_tap) == t - (int'(C) - 1)) v = ~v;
                end else if (noisy) begin
                    v = 1'($urandom);
                end
                din  = v;
                tick = 1'b1;
                if (busy_kick && b == 1 && t == 3) start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                if (b == int'(n) - 1 && t == int'(C) + 1) begin
                    check({req, " R6 done on last tap"}, 64'(done), 64'd1);
                    check({req, " R5 word"}, 64'(word), 64'(expect_word(data, n)));
                end else if (b == int'(n) - 1 && t == int'(C)) begin
                    check({req, " R6 no early done"}, 64'(done_seen), 64'd0);
                end
                tick = 1'b0;
                din  = 1'($urandom);
                for (int g = 0; g < int'($urandom % 3); g++) @(negedge clk);
            end
        end
        repeat (4) @(negedge clk);
        check({req, " R6 single done"}, 64'(done_seen), 64'd1);
        check({req, " R9 word held"}, 64'(word), 64'(expect_word(data, n)));
    endtask

    initial begin
        logic [MAXBITS-1:0] hold;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 word after reset", 64'(word), 64'd0);
        check("R1 done after reset", 64'(done), 64'd0);

        // directed: clean frames, short and alternating
        frame(1, 32'h1, 1'b0, 1'b0, "R2 single bit");
        frame(8, 32'hA5, 1'b0, 1'b0, "R3 clean byte");
        // R4: off-centre noise and one bad tap per bit
        frame(12, 32'h0000_0C3A, 1'b1, 1'b0, "R4 noisy");
        // R7: strobe while busy
        frame(10, 32'h0000_02D1, 1'b1, 1'b1, "R7 busy start");
        // R8: oversized length clamps to full word
        frame(40, 32'hDEAD_BEEF, 1'b1, 1'b0, "R8 clamp");

        // R8: zero length ignored, R9 word kept
        hold = word;
        done_seen = 0;
        @(negedge clk);
        nbits = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < int'(OSR) * 2; t++) begin
            tick = 1'b1; din = 1'($urandom);
            @(negedge clk);
            tick = 1'b0;
        end
        check("R8 zero length no done", 64'(done_seen), 64'd0);
        check("R8 zero length word kept", 64'(word), 64'(hold));

        // random frames
        for (int k = 0; k < 20; k++) begin
            int unsigned n;
            logic [MAXBITS-1:0] d;
            n = 1 + ($urandom % MAXBITS);
            d = MAXBITS'($urandom);
            frame(n, d, 1'b1, (k % 5) == 0, "R5 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule